// File: doc/BRIEF.md
# Multiprocessor Priority Interrupt Controller

This block gathers a set of external interrupt lines and steers each one to one or more processor targets. Each line is qualified by a programmable polarity and by edge or level sense. A per-source configuration word holds a mask bit, a 4-bit priority and an 8-bit vector. A per-source destination word selects the processors that may take it. For every processor the block picks, in the same cycle, the best pending source. That source must be unmasked, routed to the processor and not already in service. Its priority must be strictly above both the processor's task priority and its highest in-service priority. The processor's interrupt output is driven while such a source exists.

Software takes an interrupt by reading the processor's acknowledge word. The read returns the winning vector and moves that source into service. When nothing qualifies, the read returns the programmable spurious vector. Writing zero to the processor's completion word retires the highest-priority source that processor has in service. Nesting therefore follows priority order. Software disables a source by setting its mask, then polls a read-only activity flag until the source is neither pending nor in service, and only then changes its other fields.

The register port is a single-cycle read/write port addressed in words. The read data is combinational, and an acknowledge read takes effect at the clock edge that ends the access. Addresses are:
- identification word: 0x00
- spurious vector: 0x01
- source s configuration: 0x20+2s
- source s destination: 0x21+2s
- processor c task priority: 0x40+4c
- processor c acknowledge: 0x41+4c
- processor c completion: 0x42+4c

Top module: `mp_irq_ctrl`

## Requirements
- R1: The identification word at 0x00 reads the highest source index in bits 7:0 and the highest processor index in bits 15:8 (0x0103 for 4 sources and 2 processors).
- R2: An acknowledge read returns the spurious vector (bits 7:0 of 0x01, reset value 0xFF) in bits 7:0 when nothing qualifies for that processor.
- R3: A source whose mask (configuration bit 31, set at reset) is 1 is never delivered to any processor.
- R4: A source is delivered only to processors whose bit is set in its destination word (bit c = processor c, reset 0).
- R5: A source reaches a processor only when its priority (configuration bits 19:16) is strictly greater than the processor's task priority (bits 3:0 of its task word, reset 0).
- R6: Among qualifying sources the highest priority wins, ties go to the lowest source index, and priority 0 is never delivered.
- R7: An acknowledge read returns the winner's vector (configuration bits 7:0) and puts it in service. An edge-sensed source (bit 23 = 0) has its pending latch cleared, so it needs a new edge to be delivered again.
- R8: A level-sensed source (bit 23 = 1) is not presented while in service, and it is presented again after completion while its qualified input stays asserted.
- R9: Bit 22 selects the active input level: 1 means active high (the reset value) and 0 means active low.
- R10: While sources are in service on a processor, only a strictly higher priority may interrupt it. A completion write retires the highest-priority in-service source of that processor.
- R11: A nonzero write to a completion word has no effect.
- R12: Configuration bit 30 is read-only and reads 1 while the source is pending or in service, including while it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | NUM_CPU | Interrupt request, one per processor |

## Verification
The threshold comparison is swept over every source priority against every task priority. This separates a strict from a non-strict comparison, and it shows that priority 0 is never delivered. Two asserted level sources are run through all 256 priority pairs and acknowledged each time. This distinguishes highest-wins from lowest-index tie breaking and from the spurious case. Edge pulses against held levels show the difference between latch clearing and re-presentation after completion. A nesting sequence of four edge sources at different priorities shows which entry a completion retires: after the first completion, a mid-priority source gets through while a lower one stays blocked. Routing, polarity, masking and the activity flag are each changed one at a time, with the other settings held fixed.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int PRIO_W = 4;
   localparam int VEC_W  = 8;
   localparam int DATA_W = 32;

   // configuration word field positions
   localparam int F_VEC  = 0;
   localparam int F_PRIO = 16;
   localparam int F_POL  = 22;
   localparam int F_LVL  = 23;
   localparam int F_ACT  = 30;
   localparam int F_MASK = 31;

   typedef struct packed {
      logic              mask;
      logic              level;
      logic              pol;
      logic [PRIO_W-1:0] prio;
      logic [VEC_W-1:0]  vec;
   } src_cfg_t;

   localparam src_cfg_t CFG_RST = '{mask: 1'b1, level: 1'b0, pol: 1'b1,
                                    prio: '0, vec: '0};

   function automatic src_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
      src_cfg_t c;
      c.mask  = w[F_MASK];
      c.level = w[F_LVL];
      c.pol   = w[F_POL];
      c.prio  = w[F_PRIO +: PRIO_W];
      c.vec   = w[F_VEC +: VEC_W];
      return c;
   endfunction

   function automatic logic [DATA_W-1:0] cfg_to_word(src_cfg_t c, logic act);
      logic [DATA_W-1:0] w;
      w                  = '0;
      w[F_MASK]          = c.mask;
      w[F_ACT]           = act;
      w[F_LVL]           = c.level;
      w[F_POL]           = c.pol;
      w[F_PRIO +: PRIO_W] = c.prio;
      w[F_VEC +: VEC_W]  = c.vec;
      return w;
   endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_pkg::*;
#(
   parameter int NUM_CPU = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               dst_we,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               irq_raw,
   input  logic               ack_take,
   input  logic               in_svc,
   output src_cfg_t           cfg,
   output logic [NUM_CPU-1:0] dest,
   output logic               pending,
   output logic               active
);
   logic in_q;
   logic qual_prev;
   logic edge_pend;
   logic qual;
   logic edge_hit;

   assign qual     = cfg.pol ? in_q : ~in_q;
   assign edge_hit = qual & ~qual_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg       <= CFG_RST;
         dest      <= '0;
         in_q      <= 1'b0;
         qual_prev <= 1'b1;
         edge_pend <= 1'b0;
      end else begin
         in_q      <= irq_raw;
         qual_prev <= qual;
         if (cfg_we) cfg  <= word_to_cfg(wdata);
         if (dst_we) dest <= wdata[NUM_CPU-1:0];
         if (cfg.level) edge_pend <= 1'b0;
         else           edge_pend <= (edge_pend & ~ack_take) | edge_hit;
      end
   end

   assign pending = cfg.level ? qual : edge_pend;
   assign active  = pending | in_svc;
endmodule

// File: rtl/irq_cpu_sel.sv
module irq_cpu_sel
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]             cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [NUM_SRC-1:0]             isr,
   input  logic [PRIO_W-1:0]              task_prio,
   output logic                           req,
   output logic [IDX_W-1:0]               win_idx,
   output logic                           eoi_valid,
   output logic [IDX_W-1:0]               eoi_idx
);
   logic [PRIO_W-1:0] isr_top;
   logic [PRIO_W-1:0] floor_p;
   logic [PRIO_W-1:0] best;

   // highest in-service priority; first index on ties
   always_comb begin
      eoi_valid = 1'b0;
      eoi_idx   = '0;
      isr_top   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (isr[s] && (!eoi_valid || prio[s] > isr_top)) begin
            eoi_valid = 1'b1;
            eoi_idx   = IDX_W'(s);
            isr_top   = prio[s];
         end
      end
   end

   assign floor_p = (isr_top > task_prio) ? isr_top : task_prio;

   // winner must beat the floor; strict compare keeps lowest index on ties
   always_comb begin
      req     = 1'b0;
      win_idx = '0;
      best    = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (cand[s] && prio[s] > floor_p && (!req || prio[s] > best)) begin
            req     = 1'b1;
            win_idx = IDX_W'(s);
            best    = prio[s];
         end
      end
   end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
   import irq_pkg::*;
#(
   parameter int              NUM_SRC  = 4,
   parameter int              NUM_CPU  = 2,
   parameter int              ADDR_W   = 8,
   parameter logic [VEC_W-1:0] SPUR_RST = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CPU-1:0] irq_out
);
   localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int A_FEAT     = 0;
   localparam int A_SPUR     = 1;
   localparam int A_SRC_BASE = 32;
   localparam int A_CPU_BASE = 64;

   if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_src
      $error("NUM_SRC must be 1..16");
   end
   if (NUM_CPU < 1 || NUM_CPU > 16) begin : g_bad_cpu
      $error("NUM_CPU must be 1..16");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must be at least 7");
   end

   logic rd_en, wr_en;
   assign rd_en = bus_sel & ~bus_wr;
   assign wr_en = bus_sel &  bus_wr;

   src_cfg_t                         cfg      [NUM_SRC];
   logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_vec;
   logic [NUM_SRC-1:0][NUM_CPU-1:0]  src_dest;
   logic [NUM_SRC-1:0]               src_pend;
   logic [NUM_SRC-1:0]               src_act;
   logic [NUM_SRC-1:0]               src_mask;
   logic [NUM_SRC-1:0]               in_svc_any;
   logic [NUM_SRC-1:0]               ack_take;

   logic [NUM_CPU-1:0][NUM_SRC-1:0]  isr_q;
   logic [NUM_CPU-1:0][PRIO_W-1:0]   task_q;
   logic [NUM_CPU-1:0][NUM_SRC-1:0]  cand;
   logic [NUM_CPU-1:0]               req;
   logic [NUM_CPU-1:0][IDX_W-1:0]    win_idx;
   logic [NUM_CPU-1:0]               eoi_valid;
   logic [NUM_CPU-1:0][IDX_W-1:0]    eoi_idx;
   logic [NUM_CPU-1:0][VEC_W-1:0]    ack_vec;
   logic [NUM_CPU-1:0]               ack_rd;
   logic [NUM_CPU-1:0]               eoi_wr;
   logic [NUM_CPU-1:0]               task_wr;
   logic [VEC_W-1:0]                 spur_q;
   logic [NUM_CPU*NUM_SRC-1:0]       isr_flat;

   assign isr_flat = isr_q;

   // ---------------- sources ----------------
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic cfg_we, dst_we;
      assign cfg_we = wr_en && bus_addr == ADDR_W'(A_SRC_BASE + 2*s);
      assign dst_we = wr_en && bus_addr == ADDR_W'(A_SRC_BASE + 2*s + 1);

      irq_src_slot #(.NUM_CPU(NUM_CPU)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .dst_we   (dst_we),
         .wdata    (bus_wdata),
         .irq_raw  (irq_in[s]),
         .ack_take (ack_take[s]),
         .in_svc   (in_svc_any[s]),
         .cfg      (cfg[s]),
         .dest     (src_dest[s]),
         .pending  (src_pend[s]),
         .active   (src_act[s])
      );
      assign prio_vec[s] = cfg[s].prio;
      assign src_mask[s] = cfg[s].mask;
   end

   // ---------------- processors ----------------
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam int BASE = A_CPU_BASE + 4*c;
      assign task_wr[c] = wr_en && bus_addr == ADDR_W'(BASE);
      assign ack_rd[c]  = rd_en && bus_addr == ADDR_W'(BASE + 1);
      assign eoi_wr[c]  = wr_en && bus_addr == ADDR_W'(BASE + 2) && bus_wdata == '0;

      irq_cpu_sel #(.NUM_SRC(NUM_SRC)) u_sel (
         .cand      (cand[c]),
         .prio      (prio_vec),
         .isr       (isr_q[c]),
         .task_prio (task_q[c]),
         .req       (req[c]),
         .win_idx   (win_idx[c]),
         .eoi_valid (eoi_valid[c]),
         .eoi_idx   (eoi_idx[c])
      );
      assign irq_out[c] = req[c];
   end

   // candidate matrix, in-service summary, acknowledge steering
   always_comb begin
      in_svc_any = '0;
      ack_take   = '0;
      for (int s = 0; s < NUM_SRC; s++)
         for (int c = 0; c < NUM_CPU; c++)
            in_svc_any[s] = in_svc_any[s] | isr_q[c][s];
      for (int c = 0; c < NUM_CPU; c++) begin
         ack_vec[c] = spur_q;
         for (int s = 0; s < NUM_SRC; s++) begin
            cand[c][s] = src_pend[s] & ~cfg[s].mask & src_dest[s][c] & ~in_svc_any[s];
            if (req[c] && win_idx[c] == IDX_W'(s)) begin
               ack_vec[c] = cfg[s].vec;
               if (ack_rd[c]) ack_take[s] = 1'b1;
            end
         end
      end
   end

   // processor state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q  <= '0;
         task_q <= '0;
         spur_q <= SPUR_RST;
      end else begin
         if (wr_en && bus_addr == ADDR_W'(A_SPUR)) spur_q <= bus_wdata[VEC_W-1:0];
         for (int c = 0; c < NUM_CPU; c++) begin
            if (task_wr[c]) task_q[c] <= bus_wdata[PRIO_W-1:0];
            if (ack_rd[c] && req[c])
               isr_q[c][win_idx[c]] <= 1'b1;
            else if (eoi_wr[c] && eoi_valid[c])
               isr_q[c][eoi_idx[c]] <= 1'b0;
         end
      end
   end

   // read port
   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         if (bus_addr == ADDR_W'(A_FEAT)) begin
            bus_rdata[7:0]  = 8'(NUM_SRC - 1);
            bus_rdata[15:8] = 8'(NUM_CPU - 1);
         end
         if (bus_addr == ADDR_W'(A_SPUR)) bus_rdata[VEC_W-1:0] = spur_q;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (bus_addr == ADDR_W'(A_SRC_BASE + 2*s))
               bus_rdata = cfg_to_word(cfg[s], src_act[s]);
            if (bus_addr == ADDR_W'(A_SRC_BASE + 2*s + 1))
               bus_rdata[NUM_CPU-1:0] = src_dest[s];
         end
         for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_addr == ADDR_W'(A_CPU_BASE + 4*c))
               bus_rdata[PRIO_W-1:0] = task_q[c];
            if (bus_addr == ADDR_W'(A_CPU_BASE + 4*c + 1))
               bus_rdata[VEC_W-1:0] = ack_vec[c];
         end
      end
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int NUM_CPU = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_CPU-1:0]         irq_out,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [VEC_W-1:0]           spur_q,
   input logic [NUM_CPU-1:0]         ack_rd,
   input logic [NUM_CPU-1:0]         eoi_wr,
   input logic [NUM_CPU*NUM_SRC-1:0] isr_flat,
   input logic [NUM_SRC-1:0]         src_act,
   input logic [NUM_SRC-1:0]         in_svc_any,
   input logic [NUM_SRC-1:0]         src_mask
);
   logic [NUM_SRC-1:0] row [NUM_CPU];
   logic [NUM_CPU-1:0] col [NUM_SRC];

   always_comb begin
      for (int c = 0; c < NUM_CPU; c++)
         for (int s = 0; s < NUM_SRC; s++) begin
            row[c][s] = isr_flat[c*NUM_SRC + s];
            col[s][c] = isr_flat[c*NUM_SRC + s];
         end
   end

   // R3: with every source masked no processor is interrupted
   a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&src_mask) |-> (irq_out == '0));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      // R2: acknowledge with no request yields the spurious vector
      a_r2_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_rd[c] && !irq_out[c]) |-> (bus_rdata[VEC_W-1:0] == spur_q));
      // R7: a taken acknowledge adds exactly one in-service entry
      a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_rd[c] && irq_out[c]) |=> ($countones(row[c]) == $past($countones(row[c])) + 1));
      // R10: a completion retires exactly one entry
      a_r10_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_wr[c] && (|row[c])) |=> ($countones(row[c]) == $past($countones(row[c])) - 1));
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
      // R12: in-service sources report activity
      a_r12_active_in_service: assert property (@(posedge clk) disable iff (!rst_n)
         in_svc_any[s] |-> src_act[s]);
      // R10: a source is in service on at most one processor
      a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[s]));
   end
endmodule

bind mp_irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_out    (irq_out),
   .bus_rdata  (bus_rdata),
   .spur_q     (spur_q),
   .ack_rd     (ack_rd),
   .eoi_wr     (eoi_wr),
   .isr_flat   (isr_flat),
   .src_act    (src_act),
   .in_svc_any (in_svc_any),
   .src_mask   (src_mask)
);

// File: tb/test_mp_irq_ctrl.sv
module test_mp_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_in = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_out;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   mp_irq_ctrl #(.NUM_SRC(4), .NUM_CPU(2), .ADDR_W(8)) i_mp_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [7:0] a_cfg(int s); return 8'(32 + 2*s); endfunction
   function automatic logic [7:0] a_dst(int s); return 8'(33 + 2*s); endfunction
   function automatic logic [7:0] a_task(int c); return 8'(64 + 4*c); endfunction
   function automatic logic [7:0] a_ack(int c); return 8'(65 + 4*c); endfunction
   function automatic logic [7:0] a_eoi(int c); return 8'(66 + 4*c); endfunction

   function automatic logic [31:0] cw(bit m, bit lv, bit pl, int p, int v);
      return (32'(m) << 31) | (32'(lv) << 23) | (32'(pl) << 22) | (32'(p) << 16) | 32'(v);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input int s);
      @(negedge clk); irq_in[s] = 1'b1;
      repeat (2) @(negedge clk); irq_in[s] = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R3 reset irq_out", 32'(irq_out), 0);
      rd(8'h00, d); chk("R1 identification", d, 32'h0000_0103);
      rd(a_cfg(0), d); chk("R3 reset config", d, 32'h8040_0000);
      rd(a_dst(0), d); chk("R4 reset destination", d, 0);
      rd(a_ack(0), d); chk("R2 reset spurious", d, 32'hFF);
      wr(8'h01, 32'h5A);
      rd(a_ack(1), d); chk("R2 programmed spurious", d, 32'h5A);
      wr(8'h01, 32'hFF);

      // masking, routing, polarity
      irq_in[0] = 1'b1;
      wr(a_dst(0), 1);
      wr(a_cfg(0), cw(1, 1, 1, 5, 8'h10));
      settle(); chk("R3 masked source quiet", 32'(irq_out), 0);
      rd(a_cfg(0), d); chk("R12 masked but active", 32'(d[30]), 1);
      wr(a_cfg(0), cw(0, 1, 1, 5, 8'h10));
      settle(); chk("R4 routed to cpu0", 32'(irq_out), 1);
      wr(a_dst(0), 2);
      settle(); chk("R4 routed to cpu1", 32'(irq_out), 2);
      rd(a_ack(1), d); chk("R7 cpu1 ack vector", d, 32'h10);
      settle(); chk("R8 level in service quiet", 32'(irq_out), 0);
      wr(a_eoi(1), 0);
      settle(); chk("R8 level re-presented", 32'(irq_out), 2);
      wr(a_dst(0), 1);
      wr(a_cfg(0), cw(0, 1, 0, 5, 8'h10));
      settle(); chk("R9 active-low line high", 32'(irq_out), 0);
      irq_in[0] = 1'b0;
      settle(); chk("R9 active-low line low", 32'(irq_out), 1);
      irq_in[0] = 1'b1;
      wr(a_cfg(0), cw(0, 1, 1, 5, 8'h10));

      // threshold sweep
      for (int p = 0; p < 16; p++) begin
         for (int t = 0; t < 16; t++) begin
            wr(a_cfg(0), cw(0, 1, 1, p, 8'h10));
            wr(a_task(0), t);
            settle();
            chk($sformatf("R5 prio %0d task %0d", p, t), 32'(irq_out[0]), 32'(p > t));
         end
      end
      wr(a_task(0), 0);
      rd(a_task(0), d); chk("R5 task readback", d, 0);

      // arbitration sweep
      irq_in[1] = 1'b1;
      wr(a_dst(1), 1);
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic [31:0] exp;
            wr(a_cfg(0), cw(0, 1, 1, a, 8'h10));
            wr(a_cfg(1), cw(0, 1, 1, b, 8'h11));
            settle();
            exp = (a == 0 && b == 0) ? 32'hFF : (a >= b) ? 32'h10 : 32'h11;
            rd(a_ack(0), d);
            chk($sformatf("R6 prio %0d vs %0d", a, b), d, exp);
            wr(a_eoi(0), 0);
         end
      end
      irq_in[1:0] = 2'b00;
      wr(a_cfg(0), cw(1, 0, 1, 0, 8'h10));
      wr(a_cfg(1), cw(1, 0, 1, 0, 8'h11));
      settle(); chk("R3 all masked", 32'(irq_out), 0);

      // edge source
      wr(a_dst(2), 1);
      wr(a_cfg(2), cw(0, 0, 1, 7, 8'h12));
      pulse(2);
      settle(); chk("R7 edge pending", 32'(irq_out), 1);
      rd(a_cfg(2), d); chk("R12 pending active", 32'(d[30]), 1);
      rd(a_ack(0), d); chk("R7 edge vector", d, 32'h12);
      settle(); chk("R7 edge taken", 32'(irq_out), 0);
      rd(a_cfg(2), d); chk("R12 in-service active", 32'(d[30]), 1);
      wr(a_eoi(0), 0);
      settle(); chk("R7 edge consumed", 32'(irq_out), 0);
      rd(a_cfg(2), d); chk("R12 idle inactive", 32'(d[30]), 0);
      rd(a_ack(0), d); chk("R7 no second delivery", d, 32'hFF);

      // level source and completion value
      wr(a_dst(3), 1);
      irq_in[3] = 1'b1;
      wr(a_cfg(3), cw(0, 1, 1, 6, 8'h13));
      settle(); chk("R8 level pending", 32'(irq_out), 1);
      rd(a_ack(0), d); chk("R8 level vector", d, 32'h13);
      settle(); chk("R8 level held off", 32'(irq_out), 0);
      wr(a_eoi(0), 5);
      settle(); chk("R11 nonzero completion ignored", 32'(irq_out), 0);
      wr(a_eoi(0), 0);
      settle(); chk("R8 level again", 32'(irq_out), 1);
      rd(a_ack(0), d); chk("R8 level vector again", d, 32'h13);
      irq_in[3] = 1'b0;
      wr(a_eoi(0), 0);
      settle(); chk("R8 level released", 32'(irq_out), 0);

      // nesting
      wr(a_cfg(0), cw(0, 0, 1, 6, 8'h10));
      wr(a_cfg(1), cw(0, 0, 1, 3, 8'h11));
      wr(a_cfg(2), cw(0, 0, 1, 4, 8'h12));
      wr(a_cfg(3), cw(0, 0, 1, 9, 8'h13));
      pulse(2); settle();
      rd(a_ack(0), d); chk("R10 first level", d, 32'h12);
      pulse(3); settle(); chk("R10 higher preempts", 32'(irq_out), 1);
      rd(a_ack(0), d); chk("R10 nested vector", d, 32'h13);
      pulse(1); settle(); chk("R10 lower blocked", 32'(irq_out), 0);
      wr(a_eoi(0), 0);
      settle(); chk("R10 still blocked", 32'(irq_out), 0);
      pulse(0); settle(); chk("R10 top entry retired", 32'(irq_out), 1);
      rd(a_ack(0), d); chk("R10 mid vector", d, 32'h10);
      wr(a_eoi(0), 0);
      wr(a_eoi(0), 0);
      settle(); chk("R10 unwound", 32'(irq_out), 1);
      rd(a_ack(0), d); chk("R10 last vector", d, 32'h11);
      wr(a_eoi(0), 0);
      settle(); chk("R10 empty", 32'(irq_out), 0);

      summary();
      $finish;
   end
endmodule